// File: doc/BRIEF.md
# Condition and Exception Flag Unit

This block keeps the processor's condition register (eight 4-bit condition fields packed into 32 bits) and the three integer exception flags: carry, overflow, and the sticky summary overflow. Every cycle it takes update requests from the execution pipeline and writes them into the registers. The sources are an integer result whose record form asks for a condition update, a compare outcome aimed at a chosen field, a floating-point record update, carry and overflow from the adder, a direct write of the exception flags, and a masked move into the whole condition register.

A branch unit reads the full register or any single field through a combinational read port. Field 0 sits in the most significant nibble. Inside a field the order is less-than, greater-than, equal, summary-overflow, from the high bit to the low bit. A field that receives condition flags also receives the summary-overflow value the exception register holds at the end of that cycle. An overflow therefore shows up in the same field write as the result that caused it.

Top module: `cond_flag_unit`

## Requirements
- R1: While `rst_n` is low and for the two clock edges after it rises, `cr_o` reads 0 and `ca_o`, `ov_o` and `so_o` read 0.
- R2: An integer record update (`rec_valid`) writes field 0 from `rec_result` taken as signed. Less-than is set for a negative value. Equal is set only for zero. Greater-than is set for any other value. Exactly one of the three is set.
- R3: The low bit of any field written with flags (R2, R4, R5) equals the summary-overflow value after the same cycle's exception update. That value includes an overflow reported in that cycle.
- R4: A compare (`cmp_valid`) writes field `cmp_sel` with `cmp_flags` = {lt, gt, eq} in its three high bits. All other fields keep their value.
- R5: A floating-point record update (`fp_valid`) writes field 1 with `fp_flags` = {lt, gt, eq} in its three high bits.
- R6: With `arith_valid` high, carry takes `arith_ca` and overflow takes `arith_ov`, and summary overflow is set when `arith_ov` is 1. Summary overflow is never cleared by arithmetic. Without `arith_valid` or `xer_wr_valid` the three flags hold.
- R7: `xer_wr_valid` loads {so, ov, ca} from `xer_wr_data[2:0]`. If `arith_valid` is high in the same cycle, carry and overflow come from the adder and summary overflow becomes `xer_wr_data[2]` OR `arith_ov`.
- R8: A move (`mv_valid`) copies nibble n of `mv_data` into field n for each set bit n of `mv_mask`. A field that also receives a flag write (R2, R4, R5) in that cycle takes the flag write.
- R9: When several flag writes target one field in a cycle, a compare wins over an integer record, and an integer record wins over a floating-point record.
- R10: `rd_field` shows field `rd_sel` of the current register without a clock delay.
- R11: Field n occupies `cr_o[31-4n:28-4n]`. Within it, bit 3 is less-than, bit 2 greater-than, bit 1 equal and bit 0 summary-overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rec_valid | input | 1 | Integer record update into field 0 |
| rec_result | input | 32 | Integer result to classify |
| cmp_valid | input | 1 | Compare outcome valid |
| cmp_sel | input | 3 | Target field of the compare |
| cmp_flags | input | 3 | {lt, gt, eq} from the compare |
| fp_valid | input | 1 | Floating-point record update into field 1 |
| fp_flags | input | 3 | {lt, gt, eq} for field 1 |
| arith_valid | input | 1 | Adder carry/overflow valid |
| arith_ca | input | 1 | Carry out of the result's top bit |
| arith_ov | input | 1 | Signed overflow |
| xer_wr_valid | input | 1 | Direct write of exception flags |
| xer_wr_data | input | 3 | {so, ov, ca} to load |
| mv_valid | input | 1 | Masked move into the condition register |
| mv_mask | input | 8 | Bit n enables field n |
| mv_data | input | 32 | Source, laid out as `cr_o` |
| rd_sel | input | 3 | Field index for the read port |
| cr_o | output | 32 | Whole condition register |
| rd_field | output | 4 | Selected field |
| ca_o | output | 1 | Carry flag |
| ov_o | output | 1 | Overflow flag |
| so_o | output | 1 | Summary overflow flag |

## Verification
The bench goes after the results at the sign boundaries: zero, the most negative value and the largest positive value. A classifier that tests the wrong bit or forgets the zero case writes two flags or the wrong flag into field 0. It drives an overflow in the same cycle as a record update or compare, where a design that copies the old summary-overflow value leaves bit 0 clear for one write. It also stacks a compare, an integer record and a floating-point record on the same field, and places moves beside flag writes. A design with the priority reversed, or one that lets the move overwrite a flag write, leaves the wrong nibble in that field. Summary overflow is checked to stay set through later arithmetic and to clear only through a direct write. The read port is swept over all eight fields to catch a reversed field order.

// File: rtl/cfu_pkg.sv
package cfu_pkg;
  localparam int CFU_FIELD_W = 4;
  localparam int CFU_REC_FIELD = 0;
  localparam int CFU_FP_FIELD  = 1;

  // One condition field, high bit first
  typedef struct packed {
    logic lt;
    logic gt;
    logic eq;
    logic so;
  } cfu_field_t;

  // {lt, gt, eq} as handed in by the producers
  typedef logic [2:0] cfu_cmp_t;
endpackage

// File: rtl/cfu_rst_sync.sv
module cfu_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage1_q;
  logic stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_sync_n = stage2_q;
endmodule

// File: rtl/cfu_xer_flags.sv
module cfu_xer_flags (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       arith_valid,
  input  logic       arith_ca,
  input  logic       arith_ov,
  input  logic       wr_valid,
  input  logic [2:0] wr_data,
  output logic       ca_q,
  output logic       ov_q,
  output logic       so_q,
  output logic       so_next
);
  logic ca_d, ov_d, so_d;
  logic flag_en;

  always_comb begin
    ca_d    = ca_q;
    ov_d    = ov_q;
    so_d    = so_q;
    flag_en = 1'b0;
    if (wr_valid) begin
      ca_d    = wr_data[0];
      ov_d    = wr_data[1];
      so_d    = wr_data[2];
      flag_en = 1'b1;
    end
    if (arith_valid) begin
      ca_d    = arith_ca;
      ov_d    = arith_ov;
      so_d    = so_d | arith_ov;
      flag_en = 1'b1;
    end
  end

  assign so_next = so_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ca_q <= 1'b0;
      ov_q <= 1'b0;
      so_q <= 1'b0;
    end else if (flag_en) begin
      ca_q <= ca_d;
      ov_q <= ov_d;
      so_q <= so_d;
    end
  end
endmodule

// File: rtl/cfu_field_slot.sv
module cfu_field_slot
  import cfu_pkg::*;
#(
  parameter int IDX   = 0,
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmp_valid,
  input  logic [SEL_W-1:0] cmp_sel,
  input  cfu_cmp_t         cmp_flags,
  input  logic             rec_valid,
  input  cfu_cmp_t         rec_flags,
  input  logic             fp_valid,
  input  cfu_cmp_t         fp_flags,
  input  logic             mv_en,
  input  logic [3:0]       mv_nib,
  input  logic             so_next,
  output cfu_field_t       field_q
);
  localparam bit IS_REC = (IDX == CFU_REC_FIELD);
  localparam bit IS_FP  = (IDX == CFU_FP_FIELD);

  logic       cmp_hit, rec_hit, fp_hit;
  cfu_field_t field_d;
  logic       field_en;

  assign cmp_hit = cmp_valid && (cmp_sel == SEL_W'(IDX));
  assign rec_hit = IS_REC && rec_valid;
  assign fp_hit  = IS_FP && fp_valid;

  // Priority: compare, integer record, floating record, move
  always_comb begin
    field_d  = field_q;
    field_en = 1'b0;
    if (cmp_hit) begin
      field_d  = {cmp_flags, so_next};
      field_en = 1'b1;
    end else if (rec_hit) begin
      field_d  = {rec_flags, so_next};
      field_en = 1'b1;
    end else if (fp_hit) begin
      field_d  = {fp_flags, so_next};
      field_en = 1'b1;
    end else if (mv_en) begin
      field_d  = mv_nib;
      field_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      field_q <= '0;
    end else if (field_en) begin
      field_q <= field_d;
    end
  end
endmodule

// File: rtl/cond_flag_unit.sv
module cond_flag_unit
  import cfu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int NFIELD = 8,
  localparam int SEL_W = $clog2(NFIELD),
  localparam int CR_W  = NFIELD * CFU_FIELD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rec_valid,
  input  logic [DATA_W-1:0] rec_result,
  input  logic              cmp_valid,
  input  logic [SEL_W-1:0]  cmp_sel,
  input  logic [2:0]        cmp_flags,
  input  logic              fp_valid,
  input  logic [2:0]        fp_flags,
  input  logic              arith_valid,
  input  logic              arith_ca,
  input  logic              arith_ov,
  input  logic              xer_wr_valid,
  input  logic [2:0]        xer_wr_data,
  input  logic              mv_valid,
  input  logic [NFIELD-1:0] mv_mask,
  input  logic [CR_W-1:0]   mv_data,
  input  logic [SEL_W-1:0]  rd_sel,
  output logic [CR_W-1:0]   cr_o,
  output logic [3:0]        rd_field,
  output logic              ca_o,
  output logic              ov_o,
  output logic              so_o
);
  logic       rst_q_n;
  logic       so_next;
  cfu_cmp_t   rec_flags;
  logic       res_neg, res_zero;
  cfu_field_t fld [NFIELD];

  cfu_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_q_n)
  );

  // Signed classification of the integer result
  assign res_neg   = rec_result[DATA_W-1];
  assign res_zero  = (rec_result == '0);
  assign rec_flags = {res_neg, ~res_neg & ~res_zero, res_zero};

  cfu_xer_flags u_xer (
    .clk         (clk),
    .rst_n       (rst_q_n),
    .arith_valid (arith_valid),
    .arith_ca    (arith_ca),
    .arith_ov    (arith_ov),
    .wr_valid    (xer_wr_valid),
    .wr_data     (xer_wr_data),
    .ca_q        (ca_o),
    .ov_q        (ov_o),
    .so_q        (so_o),
    .so_next     (so_next)
  );

  for (genvar n = 0; n < NFIELD; n++) begin : g_field
    localparam int HI = CR_W - 1 - CFU_FIELD_W * n;
    cfu_field_slot #(
      .IDX   (n),
      .SEL_W (SEL_W)
    ) u_slot (
      .clk       (clk),
      .rst_n     (rst_q_n),
      .cmp_valid (cmp_valid),
      .cmp_sel   (cmp_sel),
      .cmp_flags (cmp_flags),
      .rec_valid (rec_valid),
      .rec_flags (rec_flags),
      .fp_valid  (fp_valid),
      .fp_flags  (fp_flags),
      .mv_en     (mv_valid & mv_mask[n]),
      .mv_nib    (mv_data[HI -: CFU_FIELD_W]),
      .so_next   (so_next),
      .field_q   (fld[n])
    );
    assign cr_o[HI -: CFU_FIELD_W] = fld[n];
  end

  assign rd_field = fld[rd_sel];
endmodule

// File: rtl/cfu_checker.sv
module cfu_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        rec_valid,
  input logic [31:0] rec_result,
  input logic        cmp_valid,
  input logic [2:0]  cmp_sel,
  input logic        fp_valid,
  input logic        arith_valid,
  input logic        arith_ov,
  input logic        xer_wr_valid,
  input logic        mv_valid,
  input logic [31:0] cr_o,
  input logic        so_o
);
  // R6: an overflow always leaves summary overflow set
  a_r6_ov_sets_so: assert property (@(posedge clk) disable iff (!rst_n)
    (arith_valid && arith_ov) |=> so_o);

  // R6: summary overflow only drops through a direct write
  a_r6_so_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (so_o && !xer_wr_valid) |=> so_o);

  // R2: a zero result leaves only the equal flag in field 0
  a_r2_zero_only_eq: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_valid && rec_result == 32'h0 && !(cmp_valid && cmp_sel == 3'd0))
      |=> (cr_o[31:29] == 3'b001));

  // R3: the compared field carries the updated summary overflow
  a_r3_cmp_so_bit: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_valid |=> (((cr_o & (32'h1000_0000 >> {$past(cmp_sel), 2'b00})) != 32'h0) == so_o));

  // R4: a lone compare touches no other field
  a_r4_cmp_isolated: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_valid && !rec_valid && !fp_valid && !mv_valid)
      |=> (((cr_o ^ $past(cr_o)) & ~(32'hF000_0000 >> {$past(cmp_sel), 2'b00})) == 32'h0));

  // R8: with no writer active the register holds
  a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmp_valid && !rec_valid && !fp_valid && !mv_valid) |=> $stable(cr_o));
endmodule

bind cond_flag_unit cfu_checker u_cfu_checker (
  .clk          (clk),
  .rst_n        (rst_q_n),
  .rec_valid    (rec_valid),
  .rec_result   (rec_result),
  .cmp_valid    (cmp_valid),
  .cmp_sel      (cmp_sel),
  .fp_valid     (fp_valid),
  .arith_valid  (arith_valid),
  .arith_ov     (arith_ov),
  .xer_wr_valid (xer_wr_valid),
  .mv_valid     (mv_valid),
  .cr_o         (cr_o),
  .so_o         (so_o)
);

// File: tb/cond_flag_unit_tb_top.sv
module cond_flag_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rec_valid = 1'b0;
  logic [31:0] rec_result = '0;
  logic        cmp_valid = 1'b0;
  logic [2:0]  cmp_sel = '0;
  logic [2:0]  cmp_flags = '0;
  logic        fp_valid = 1'b0;
  logic [2:0]  fp_flags = '0;
  logic        arith_valid = 1'b0;
  logic        arith_ca = 1'b0;
  logic        arith_ov = 1'b0;
  logic        xer_wr_valid = 1'b0;
  logic [2:0]  xer_wr_data = '0;
  logic        mv_valid = 1'b0;
  logic [7:0]  mv_mask = '0;
  logic [31:0] mv_data = '0;
  logic [2:0]  rd_sel = '0;
  logic [31:0] cr_o;
  logic [3:0]  rd_field;
  logic        ca_o, ov_o, so_o;

  int total = 0;
  int bad = 0;

  // Reference state
  logic [3:0] m_fld [8];
  logic       m_ca, m_ov, m_so;

  always #10 clk = ~clk;

  cond_flag_unit dut_i (
    .clk(clk), .rst_n(rst_n),
    .rec_valid(rec_valid), .rec_result(rec_result),
    .cmp_valid(cmp_valid), .cmp_sel(cmp_sel), .cmp_flags(cmp_flags),
    .fp_valid(fp_valid), .fp_flags(fp_flags),
    .arith_valid(arith_valid), .arith_ca(arith_ca), .arith_ov(arith_ov),
    .xer_wr_valid(xer_wr_valid), .xer_wr_data(xer_wr_data),
    .mv_valid(mv_valid), .mv_mask(mv_mask), .mv_data(mv_data),
    .rd_sel(rd_sel), .cr_o(cr_o), .rd_field(rd_field),
    .ca_o(ca_o), .ov_o(ov_o), .so_o(so_o)
  );

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [2:0] classify(input logic [31:0] v);
    if ($signed(v) < 0) return 3'b100;
    if (v == 0) return 3'b001;
    return 3'b010;
  endfunction

  function automatic logic [31:0] m_cr();
    logic [31:0] r;
    for (int n = 0; n < 8; n++) r[31-4*n -: 4] = m_fld[n];
    return r;
  endfunction

  task automatic model_step();
    logic so_new;
    so_new = xer_wr_valid ? xer_wr_data[2] : m_so;
    if (arith_valid && arith_ov) so_new = 1'b1;
    if (arith_valid) begin
      m_ca = arith_ca; m_ov = arith_ov;
    end else if (xer_wr_valid) begin
      m_ca = xer_wr_data[0]; m_ov = xer_wr_data[1];
    end
    m_so = so_new;
    for (int n = 0; n < 8; n++) begin
      if (cmp_valid && cmp_sel == n[2:0]) m_fld[n] = {cmp_flags, so_new};
      else if (rec_valid && n == 0) m_fld[n] = {classify(rec_result), so_new};
      else if (fp_valid && n == 1) m_fld[n] = {fp_flags, so_new};
      else if (mv_valid && mv_mask[n]) m_fld[n] = mv_data[31-4*n -: 4];
    end
  endtask

  task automatic compare_all(input string tag);
    chk(tag, "cr", cr_o, m_cr());
    chk(tag, "ca", {31'b0, ca_o}, {31'b0, m_ca});
    chk(tag, "ov", {31'b0, ov_o}, {31'b0, m_ov});
    chk(tag, "so", {31'b0, so_o}, {31'b0, m_so});
    chk("R10", "rd_field", {28'b0, rd_field}, {28'b0, m_fld[rd_sel]});
  endtask

  task automatic idle_inputs();
    rec_valid = 0; cmp_valid = 0; fp_valid = 0; arith_valid = 0;
    xer_wr_valid = 0; mv_valid = 0;
  endtask

  // Inputs are set at a falling edge; result is sampled at the next one
  task automatic tick(input string tag);
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare_all(tag);
    idle_inputs();
  endtask

  initial begin
    #3_000_000;
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int n = 0; n < 8; n++) m_fld[n] = '0;
    m_ca = 0; m_ov = 0; m_so = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    compare_all("R1");

    // R2: classification at the sign boundaries
    rec_valid = 1; rec_result = 32'h0000_0005;      tick("R2");
    rec_valid = 1; rec_result = 32'h8000_0000;      tick("R2");
    rec_valid = 1; rec_result = 32'h0;              tick("R2");
    rec_valid = 1; rec_result = 32'h7FFF_FFFF;      tick("R2");
    rec_valid = 1; rec_result = 32'hFFFF_FFFF;      tick("R2");

    // R6: carry and overflow, summary stays set
    arith_valid = 1; arith_ca = 1; arith_ov = 0;    tick("R6");
    arith_valid = 1; arith_ca = 0; arith_ov = 1;    tick("R6");
    arith_valid = 1; arith_ca = 1; arith_ov = 0;    tick("R6");
    tick("R6");

    // R7: direct write clears, then write plus adder in one cycle
    xer_wr_valid = 1; xer_wr_data = 3'b000;         tick("R7");
    xer_wr_valid = 1; xer_wr_data = 3'b011;
    arith_valid = 1; arith_ca = 0; arith_ov = 1;    tick("R7");
    xer_wr_valid = 1; xer_wr_data = 3'b000;         tick("R7");

    // R3: overflow in the same cycle as a record update
    rec_valid = 1; rec_result = 32'h1234;
    arith_valid = 1; arith_ov = 1; arith_ca = 0;    tick("R3");
    xer_wr_valid = 1; xer_wr_data = 3'b000;         tick("R3");

    // R4, R11: compare into every field
    for (int n = 0; n < 8; n++) begin
      cmp_valid = 1; cmp_sel = n[2:0]; rd_sel = n[2:0];
      cmp_flags = (n % 3 == 0) ? 3'b100 : ((n % 3 == 1) ? 3'b010 : 3'b001);
      tick("R4 R11");
    end
    cmp_valid = 1; cmp_sel = 3'd6; cmp_flags = 3'b100;
    arith_valid = 1; arith_ov = 1;                  tick("R3");

    // R5: floating record into field 1
    xer_wr_valid = 1; xer_wr_data = 3'b000;         tick("R7");
    fp_valid = 1; fp_flags = 3'b010; rd_sel = 3'd1; tick("R5");

    // R9: stacked writers
    cmp_valid = 1; cmp_sel = 3'd0; cmp_flags = 3'b010;
    rec_valid = 1; rec_result = 32'h0;              tick("R9");
    cmp_valid = 1; cmp_sel = 3'd1; cmp_flags = 3'b001;
    fp_valid = 1; fp_flags = 3'b100;                tick("R9");
    rec_valid = 1; rec_result = 32'hF000_0000;
    fp_valid = 1; fp_flags = 3'b001; rd_sel = 3'd0; tick("R9");

    // R8: moves, alone and colliding with flag writes
    mv_valid = 1; mv_mask = 8'hFF; mv_data = 32'h1234_5678; tick("R8");
    mv_valid = 1; mv_mask = 8'h5A; mv_data = 32'hFEDC_BA98; tick("R8");
    mv_valid = 1; mv_mask = 8'hFF; mv_data = 32'hFFFF_FFFF;
    cmp_valid = 1; cmp_sel = 3'd5; cmp_flags = 3'b001;
    rec_valid = 1; rec_result = 32'h9;                      tick("R8");
    mv_valid = 1; mv_mask = 8'h02; mv_data = 32'h0F00_0000;
    fp_valid = 1; fp_flags = 3'b100;                        tick("R8");

    // R10: read port sweep without writes
    for (int n = 0; n < 8; n++) begin
      rd_sel = n[2:0];
      #1;
      chk("R10", "sweep", {28'b0, rd_field}, {28'b0, m_fld[n]});
    end

    // R9: mixed traffic
    for (int i = 0; i < 300; i++) begin
      rec_valid = $urandom_range(0, 1) == 1;
      rec_result = $urandom() >> $urandom_range(0, 31);
      if ($urandom_range(0, 7) == 0) rec_result = 32'h0;
      cmp_valid = $urandom_range(0, 2) == 0;
      cmp_sel = 3'($urandom_range(0, 7));
      cmp_flags = 3'($urandom_range(0, 7));
      fp_valid = $urandom_range(0, 2) == 0;
      fp_flags = 3'($urandom_range(0, 7));
      arith_valid = $urandom_range(0, 1) == 1;
      arith_ca = $urandom_range(0, 1) == 1;
      arith_ov = $urandom_range(0, 5) == 0;
      xer_wr_valid = $urandom_range(0, 6) == 0;
      xer_wr_data = 3'($urandom_range(0, 7));
      mv_valid = $urandom_range(0, 3) == 0;
      mv_mask = 8'($urandom_range(0, 255));
      mv_data = $urandom();
      rd_sel = 3'($urandom_range(0, 7));
      tick("R9 mix");
    end

    // R1: reset mid-run clears everything
    rst_n = 1'b0;
    for (int n = 0; n < 8; n++) m_fld[n] = '0;
    m_ca = 0; m_ov = 0; m_so = 0;
    @(negedge clk);
    compare_all("R1");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    compare_all("R1");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule